// File: doc/BRIEF.md
# Serial-Loaded Twelve-Channel DAC Code Bank

This block is the digital side of a multi-channel 8-bit converter. A host drives three wires: a serial bit, a shift clock and a load strobe. Every rising shift-clock edge pushes the serial bit into a 12-bit shift register. A 12-bit word holds a 4-bit channel select in its upper bits and an 8-bit code in its lower bits. When the load strobe rises, the select is decoded and the code is written into the matching channel's 8-bit holding register. The twelve holding registers drive the converter ladders, which are not part of this block.

The top bit of the shift register is brought out on a pin. That pin can feed the serial input of a second bank, so several banks can share one bus. For a chain of N banks the host shifts 12×N bits, sending the word for the bank farthest down the chain first. It then raises the shared load strobe once, and every bank decodes the word it holds.

All three serial pins are sampled by the system clock through synchronizer flops. Edges on them are found by comparing each sampled value with its value one cycle earlier. The shift clock must therefore stay high and low for several system-clock cycles.

Top module: `sdac_bank`

## Requirements
- R1: While `rst` is high at a `clk` edge, all twelve channel codes and the shift register clear to zero, so `dac_codes` and `ser_dout` read 0.
- R2: Each rising edge of `ser_clk` shifts `ser_din` into bit 0 of the shift register and moves the other bits up by one. Bits are sent MSB first, and `ser_dout` always shows bit 11. After a word has been shifted in, the next twelve shifts present its bits 11 down to 0 on `ser_dout`, in that order.
- R3: In the 12-bit word, bits 11..8 are the channel select and bits 7..0 are the code.
- R4: A rising edge of `ser_load` with select value n in 1..12 writes the code into channel n. Channel n is `dac_codes[(n-1)*8 +: 8]`. At most one channel is written per load.
- R5: A load with select value 0, 13, 14 or 15 leaves all twelve channels unchanged.
- R6: Channels that are not selected keep their codes across any number of loads.
- R7: Each rising edge of `ser_load` gives one write. Holding `ser_load` high and shifting a new word in does not write that word until `ser_load` falls and rises again.
- R8: Shifting while `ser_load` stays low never changes any channel code.
- R9: With two banks chained (`ser_dout` of the near bank into `ser_din` of the far bank), 24 shifts carrying the far word first and then the near word, followed by one shared load, update both banks from their own words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial pins |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock; its rising edge shifts one bit in |
| ser_din | input | 1 | Serial data in, MSB first |
| ser_load | input | 1 | Load strobe; its rising edge writes the decoded channel |
| ser_dout | output | 1 | Shift register bit 11, for chaining to the next bank |
| dac_codes | output | 96 | Twelve 8-bit channel codes; channel n is bits (n-1)*8+7 .. (n-1)*8 |

## Verification
The bench writes every select value from 1 to 12 and checks the whole bank after each write. An off-by-one decoder would show up as a code landing in a neighbouring channel, and a wrong field split as a garbled code. The out-of-range selects 0 and 13 to 15 are sent with a distinctive code. A decoder that wraps or truncates the select would let that code appear in some channel.

A strobe is held high while a fresh word is shifted in. A level-sensitive load would copy the new code at once instead of waiting for the next rising edge. The bench also shifts a word with the strobe low, which catches a bank that writes while shifting.

Two banks are chained and checked:
- `ser_dout` is checked bit by bit after a word has been shifted in. A wrong shift direction or a tap on the wrong bit breaks this order.
- The bits shifted through the near bank must arrive intact in the far bank. A chain that adds or drops a stage leaves the wrong code in one of the two banks.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  localparam int unsigned DEF_NUM_CH      = 12;
  localparam int unsigned DEF_CODE_W      = 8;
  localparam int unsigned DEF_ADDR_W      = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // Index of each synchronized serial pin inside the sampled bus
  typedef enum int unsigned {
    PIN_LOAD = 0,
    PIN_DIN  = 1,
    PIN_SCK  = 2
  } pin_idx_e;

  localparam int unsigned PIN_COUNT = 3;

  // Select value that addresses zero-based channel idx (selects start at 1)
  function automatic int unsigned sel_of_chan(input int unsigned idx);
    return idx + 1;
  endfunction

endpackage

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic ser_din,
  input  logic ser_load,
  output logic shift_pulse,
  output logic load_pulse,
  output logic din_sync
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [PIN_COUNT-1:0] raw;
  logic [PIN_COUNT-1:0] pipe [SYNC_STAGES];
  logic                 sck_prev;
  logic                 load_prev;

  always_comb begin
    raw           = '0;
    raw[PIN_SCK]  = ser_clk;
    raw[PIN_DIN]  = ser_din;
    raw[PIN_LOAD] = ser_load;
  end

  // Chain of synchronizer stages; the length is a parameter
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev  <= 1'b0;
      load_prev <= 1'b0;
    end else begin
      sck_prev  <= pipe[LAST][PIN_SCK];
      load_prev <= pipe[LAST][PIN_LOAD];
    end
  end

  assign shift_pulse = pipe[LAST][PIN_SCK]  & ~sck_prev;
  assign load_pulse  = pipe[LAST][PIN_LOAD] & ~load_prev;
  assign din_sync    = pipe[LAST][PIN_DIN];

endmodule

// File: rtl/sdac_shreg.sv
module sdac_shreg #(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word_q,
  output logic              msb_out
);

  always_ff @(posedge clk) begin
    if (rst)           word_q <= '0;
    else if (shift_en) word_q <= {word_q[WORD_W-2:0], bit_in};
  end

  assign msb_out = word_q[WORD_W-1];

endmodule

// File: rtl/sdac_decode.sv
module sdac_decode
  import sdac_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned CODE_W = DEF_CODE_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic [ADDR_W+CODE_W-1:0] word,
  input  logic                     strobe,
  output logic [NUM_CH-1:0]        wr_en,
  output logic [CODE_W-1:0]        wr_code
);

  localparam int unsigned WORD_W = ADDR_W + CODE_W;

  logic [ADDR_W-1:0] sel;

  assign sel     = word[WORD_W-1 -: ADDR_W];
  assign wr_code = word[CODE_W-1:0];

  // One comparator per channel; unused select values match none of them
  for (genvar c = 0; c < NUM_CH; c++) begin : g_match
    localparam logic [ADDR_W-1:0] MY_SEL = ADDR_W'(sel_of_chan(c));
    assign wr_en[c] = strobe & (sel == MY_SEL);
  end

endmodule

// File: rtl/sdac_chanregs.sv
module sdac_chanregs #(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned CODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        wr_en,
  input  logic [CODE_W-1:0]        wr_code,
  output logic [NUM_CH*CODE_W-1:0] codes
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [CODE_W-1:0] hold_q;

    always_ff @(posedge clk) begin
      if (rst)           hold_q <= '0;
      else if (wr_en[c]) hold_q <= wr_code;
    end

    assign codes[c*CODE_W +: CODE_W] = hold_q;
  end

endmodule

// File: rtl/sdac_bank.sv
module sdac_bank
  import sdac_pkg::*;
#(
  parameter int unsigned NUM_CH      = DEF_NUM_CH,
  parameter int unsigned CODE_W      = DEF_CODE_W,
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ser_clk,
  input  logic                     ser_din,
  input  logic                     ser_load,
  output logic                     ser_dout,
  output logic [NUM_CH*CODE_W-1:0] dac_codes
);

  localparam int unsigned WORD_W = ADDR_W + CODE_W;

  logic              shift_pulse;
  logic              load_pulse;
  logic              din_sync;
  logic [WORD_W-1:0] sr_q;
  logic [NUM_CH-1:0] wr_en;
  logic [CODE_W-1:0] wr_code;

  sdac_front #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_front (
    .clk         (clk),
    .rst         (rst),
    .ser_clk     (ser_clk),
    .ser_din     (ser_din),
    .ser_load    (ser_load),
    .shift_pulse (shift_pulse),
    .load_pulse  (load_pulse),
    .din_sync    (din_sync)
  );

  sdac_shreg #(
    .WORD_W (WORD_W)
  ) u_shreg (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_pulse),
    .bit_in   (din_sync),
    .word_q   (sr_q),
    .msb_out  (ser_dout)
  );

  sdac_decode #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W),
    .ADDR_W (ADDR_W)
  ) u_decode (
    .word    (sr_q),
    .strobe  (load_pulse),
    .wr_en   (wr_en),
    .wr_code (wr_code)
  );

  sdac_chanregs #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_code (wr_code),
    .codes   (dac_codes)
  );

endmodule

// File: rtl/sdac_bank_chk.sv
module sdac_bank_chk #(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       shift_pulse,
  input logic                       load_pulse,
  input logic [ADDR_W+CODE_W-1:0]   sr_q,
  input logic [NUM_CH-1:0]          wr_en,
  input logic                       ser_dout,
  input logic [NUM_CH*CODE_W-1:0]   dac_codes
);

  localparam int unsigned WORD_W = ADDR_W + CODE_W;

  logic [ADDR_W-1:0] sel;
  logic              sel_bad;

  assign sel     = sr_q[WORD_W-1 -: ADDR_W];
  assign sel_bad = (sel == '0) || (sel > ADDR_W'(NUM_CH));

  // R1: the cycle after a reset, bank and shift register read zero
  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dac_codes == '0 && sr_q == '0 && !ser_dout));

  // R2: a shift moves the bit below the MSB up to the output pin
  p_shift_dout_r2: assert property (@(posedge clk) disable iff (rst)
    shift_pulse |=> (ser_dout == $past(sr_q[WORD_W-2])));

  // R2: no shift edge, no change in the shift register
  p_sr_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !shift_pulse |=> $stable(sr_q));

  // R4: at most one channel is written at a time
  p_onehot_we_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));

  // R5: an out-of-range select changes nothing
  p_bad_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (load_pulse && sel_bad) |=> $stable(dac_codes));

  // R7: a write enable only appears on a load edge
  p_we_needs_edge_r7: assert property (@(posedge clk) disable iff (rst)
    (|wr_en) |-> load_pulse);

  // R8: without a load edge the bank holds its codes
  p_no_load_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load_pulse |=> $stable(dac_codes));

endmodule

bind sdac_bank sdac_bank_chk #(
  .NUM_CH (NUM_CH),
  .CODE_W (CODE_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .shift_pulse (shift_pulse),
  .load_pulse  (load_pulse),
  .sr_q        (sr_q),
  .wr_en       (wr_en),
  .ser_dout    (ser_dout),
  .dac_codes   (dac_codes)
);

// File: tb/sdac_bank_tb.sv
module sdac_bank_tb;

  localparam int NCH  = 12;
  localparam int CW   = 8;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_din = 1'b0;
  logic ser_load = 1'b0;
  logic near_dout;
  logic far_dout;
  logic [NCH*CW-1:0] near_codes;
  logic [NCH*CW-1:0] far_codes;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [CW-1:0] exp_code [NCH];

  always #2.5 clk = ~clk;

  sdac_bank u_dut (
    .clk (clk), .rst (rst), .ser_clk (ser_clk), .ser_din (ser_din),
    .ser_load (ser_load), .ser_dout (near_dout), .dac_codes (near_codes)
  );

  sdac_bank u_far (
    .clk (clk), .rst (rst), .ser_clk (ser_clk), .ser_din (near_dout),
    .ser_load (ser_load), .ser_dout (far_dout), .dac_codes (far_codes)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_bank(input string tag);
    for (int c = 0; c < NCH; c++)
      chk(tag, 32'(near_codes[c*CW +: CW]), 32'(exp_code[c]));
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk);
    ser_din = b;
    repeat (HALF) @(negedge clk);
    ser_clk = 1'b1;
    repeat (HALF) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic send_word(input logic [11:0] w);
    for (int i = 11; i >= 0; i--) shift_bit(w[i]);
    repeat (HALF) @(negedge clk);
  endtask

  task automatic pulse_load();
    @(negedge clk);
    ser_load = 1'b1;
    repeat (8) @(negedge clk);
    ser_load = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int c = 0; c < NCH; c++) exp_code[c] = '0;
    chk("R1 dout", 32'(near_dout), 32'd0);
    check_bank("R1 bank");
  endtask

  task automatic t_each_channel();
    for (int n = 1; n <= NCH; n++) begin
      logic [7:0] code;
      code = 8'((n * 37 + 5) & 8'hFF);
      send_word({4'(n), code});
      pulse_load();
      exp_code[n-1] = code;
      check_bank("R3 R4 R6 select");
    end
  endtask

  task automatic t_bad_addr();
    logic [3:0] bad [4] = '{4'd0, 4'd13, 4'd14, 4'd15};
    for (int k = 0; k < 4; k++) begin
      send_word({bad[k], 8'hA5});
      pulse_load();
      check_bank("R5 bad select");
    end
  endtask

  task automatic t_rewrite_one();
    send_word({4'd5, 8'h3C});
    pulse_load();
    exp_code[4] = 8'h3C;
    check_bank("R6 others hold");
  endtask

  task automatic t_no_load();
    send_word({4'd3, 8'h5A});
    check_bank("R8 shift no load");
  endtask

  task automatic t_load_held();
    send_word({4'd2, 8'h11});
    @(negedge clk);
    ser_load = 1'b1;
    repeat (10) @(negedge clk);
    exp_code[1] = 8'h11;
    check_bank("R7 first edge");
    send_word({4'd2, 8'h99});
    check_bank("R7 held no rewrite");
    ser_load = 1'b0;
    repeat (8) @(negedge clk);
    check_bank("R7 fall no write");
    pulse_load();
    exp_code[1] = 8'h99;
    check_bank("R7 next edge");
  endtask

  task automatic t_dout();
    logic [11:0] w = 12'hB4D;
    logic [11:0] v = 12'h000;
    send_word(w);
    for (int k = 0; k < 12; k++) begin
      chk("R2 dout order", 32'(near_dout), 32'(w[11-k]));
      shift_bit(v[11-k]);
      repeat (HALF) @(negedge clk);
    end
    check_bank("R8 after dout");
  endtask

  task automatic t_cascade();
    send_word({4'd7, 8'hC3});
    send_word({4'd9, 8'h6E});
    pulse_load();
    exp_code[8] = 8'h6E;
    check_bank("R9 near bank");
    chk("R9 far ch7", 32'(far_codes[6*CW +: CW]), 32'hC3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_each_channel();
    t_bad_addr();
    t_rewrite_one();
    t_no_load();
    t_load_held();
    t_dout();
    t_cascade();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule